// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a serial EEPROM that speaks the classic three-wire read protocol (select, shift clock, data toward the device, data back from the device). A host places a word address and an address-width choice on its inputs and pulses a start strobe. The block frames the access, shifts out a read opcode, which carries its own leading start bit, followed by the address. It then clocks the 16-bit word back in, most significant bit first, and presents it with a one-cycle done strobe. Every level on the serial pins is held for a programmable number of system clocks, so slow parts can meet their setup and hold times.

When reset is released, the block configures itself before accepting host requests. It reads word 0 with 8-bit addressing. If the value returned is the signature 0x8129, the attached part uses 8-bit addresses; otherwise it uses 6-bit addresses. With the width now known, it reads words 7, 8 and 9 and assembles them into a 48-bit station address. It then raises a ready flag and serves host reads.

Top module: `uwire_eeprom_reader`

## Requirements
- R1: While reset is held, and in the cycle that follows it, `ee_cs`, `ee_sk`, `ee_do`, `rd_done` and `init_done` are 0 and `busy` is 1. Reset is synchronous and active low.
- R2: An access runs through the following phases in order:
  - one phase with select low;
  - one phase with select high;
  - the opcode bits 1,1,0, then the address bits, MSB first. Each bit is placed on `ee_do` for one phase with `ee_sk` low and held for one further phase with `ee_sk` high.
- R3: After the last address bit there is one phase with select high and `ee_sk` and `ee_do` low. Then come 16 pairs of phases: `ee_sk` high, sampling `ee_di` in the last cycle of the phase, then `ee_sk` low. The word is assembled MSB first. A final phase with select low follows.
- R4: Each phase lasts max(`clk_div`, 2) system clock cycles. A value of 0 or 1 behaves as 2.
- R5: With `host_wide`=1, all 8 address bits are sent. With `host_wide`=0, only `host_addr[5:0]` is sent and bits 7:6 are ignored.
- R6: `busy` rises in the cycle after an accepted start and falls in the cycle in which `rd_done` is 1 for one cycle with `rd_word` valid. A start seen while `busy` is high does not change the pins or the result.
- R7: After reset, word 0 is read with 8-bit addressing. `wide_det` becomes 1 if it returned 0x8129, otherwise 0.
- R8: Words 7, 8 and 9 are then read using the detected width. `station_addr[15:0]` is word 7, `[31:16]` is word 8 and `[47:32]` is word 9, so each word's low byte is the lower-numbered byte. Then `init_done` rises and stays high. `rd_done` does not pulse for these reads, and host starts made before `init_done` are ignored.
- R9: During configuration, consecutive reads are separated by exactly two idle cycles. The first read begins at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | 8 | System cycles per serial phase (minimum 2) |
| host_start | input | 1 | Start strobe for a host read |
| host_addr | input | 8 | Word address for a host read |
| host_wide | input | 1 | 1: 8-bit address, 0: 6-bit address |
| rd_word | output | 16 | Word returned by the last read |
| rd_done | output | 1 | One-cycle strobe when a host read completes |
| busy | output | 1 | Configuration or access in progress |
| init_done | output | 1 | Configuration sequence finished |
| wide_det | output | 1 | Detected address width (1 = 8 bits) |
| station_addr | output | 48 | Station address assembled from words 7 to 9 |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_do | output | 1 | Serial data toward the EEPROM |
| ee_di | input | 1 | Serial data from the EEPROM |

## Verification
The hardest situation to reach is the narrow-address outcome of autodetection. There, the 8-bit signature read goes to a part that only decodes 6 address bits, so the part starts returning data two clock edges early and the block sees a shifted value. The bench reaches it with a behavioural EEPROM model whose address width can be set and which counts incoming shift-clock edges exactly as a real part would. The signature mismatch and the following 6-bit reads of words 7 to 9 therefore come out of the protocol itself. Start strobes are also fired in the middle of configuration and in the middle of a host read, and the per-cycle pin comparison shows they have no effect.

// File: rtl/uwire_eeprom_pkg.sv
// Shared types for the three-wire EEPROM reader.
// Assumes: one read opcode only; its three bits include the start bit.
package uwire_eeprom_pkg;

    typedef enum logic [3:0] {
        E_IDLE, E_CSLO, E_CSHI, E_CLO, E_CHI, E_GAP, E_DHI, E_DLO, E_END
    } eng_state_e;

    typedef enum logic [1:0] {
        I_SIG, I_STA, I_READY
    } init_state_e;

    localparam int unsigned CMD_BITS = 3;
    localparam logic [2:0]  READ_OP  = 3'b110;

endpackage

// File: rtl/uwire_phase_timer.sv
// Phase timer: pulses tick in the last cycle of each serial phase.
// Assumes: a phase lasts max(div, 2) cycles; counting restarts whenever en is low.
module uwire_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Effective phase length with the lower clamp applied.
    always_comb lim = (div < MIN_DIV) ? MIN_DIV : div;

    assign tick = en && (cnt >= lim - ONE);

    // Cycle counter within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + ONE;
    end

    // A disabled timer always begins the next phase from zero.
    assert_timer_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

endmodule

// File: rtl/uwire_read_engine.sv
// Read engine: runs one complete read access on the three-wire bus.
// Assumes: go is honoured only when idle; ee_di is stable while ee_sk is high.
module uwire_read_engine
    import uwire_eeprom_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 8,
    parameter int NARROW_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic              active,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    input  logic              ee_di
);
    localparam int CMD_W = CMD_BITS + ADDR_W;
    localparam int MAXB  = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    eng_state_e       st;
    logic [CMD_W-1:0] cmd;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic [CMD_W-1:0] cmd_load;
    logic [CNT_W-1:0] bits_load;

    uwire_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st != E_IDLE),
        .div  (div),
        .tick (tick)
    );

    // Opcode plus address, left-aligned, for the chosen width.
    always_comb begin
        if (wide) begin
            cmd_load  = {READ_OP, addr};
            bits_load = CNT_W'(CMD_W);
        end else begin
            cmd_load  = {READ_OP, addr[NARROW_W-1:0], {(ADDR_W-NARROW_W){1'b0}}};
            bits_load = CNT_W'(CMD_BITS + NARROW_W);
        end
    end

    // Phase sequencer: command shift-out, then data shift-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= E_IDLE;
            cmd  <= '0;
            cnt  <= '0;
            word <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == E_IDLE) begin
                if (go) begin
                    st  <= E_CSLO;
                    cmd <= cmd_load;
                    cnt <= bits_load;
                end
            end else if (tick) begin
                case (st)
                    E_CSLO: st <= E_CSHI;
                    E_CSHI: st <= E_CLO;
                    E_CLO:  st <= E_CHI;
                    E_CHI: begin
                        if (cnt == CNT_W'(1)) begin
                            st <= E_GAP;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                            cmd <= {cmd[CMD_W-2:0], 1'b0};
                            st  <= E_CLO;
                        end
                    end
                    E_GAP: begin
                        cnt <= CNT_W'(WORD_W);
                        st  <= E_DHI;
                    end
                    E_DHI: begin
                        word <= {word[WORD_W-2:0], ee_di};
                        cnt  <= cnt - CNT_W'(1);
                        st   <= E_DLO;
                    end
                    E_DLO: st <= (cnt == '0) ? E_END : E_DHI;
                    E_END: begin
                        st   <= E_IDLE;
                        done <= 1'b1;
                    end
                    default: st <= E_IDLE;
                endcase
            end
        end
    end

    assign active = (st != E_IDLE);
    assign ee_cs  = !(st == E_IDLE || st == E_CSLO || st == E_END);
    assign ee_sk  = (st == E_CHI) || (st == E_DHI);
    assign ee_do  = ((st == E_CLO) || (st == E_CHI)) && cmd[CMD_W-1];

    // Assertion support: count shift-clock rises in each access.
    logic             sk_q;
    logic [CNT_W:0]   rise_cnt;
    logic [CNT_W:0]   rise_exp;

    // Edge counter, cleared at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q     <= 1'b0;
            rise_cnt <= '0;
            rise_exp <= '0;
        end else begin
            sk_q <= ee_sk;
            if (st == E_IDLE && go) begin
                rise_cnt <= '0;
                rise_exp <= (CNT_W+1)'(bits_load) + (CNT_W+1)'(WORD_W);
            end else if (ee_sk && !sk_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != E_IDLE && !tick) |=> $stable({ee_cs, ee_sk, ee_do}));

    assert_edge_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rise_cnt == rise_exp));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/uwire_eeprom_reader.sv
// Top: self-configuration after reset, then host-driven word reads.
// Assumes: clk_div is held steady during an access; a signature word selects the width.
module uwire_eeprom_reader
    import uwire_eeprom_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter int          WORD_W    = 16,
    parameter int          ADDR_W    = 8,
    parameter int          NARROW_W  = 6,
    parameter int          STA_BASE  = 7,
    parameter int          STA_WORDS = 3,
    parameter logic [15:0] SIG_WORD  = 16'h8129
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DIV_W-1:0]            clk_div,
    input  logic                        host_start,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic                        host_wide,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        rd_done,
    output logic                        busy,
    output logic                        init_done,
    output logic                        wide_det,
    output logic [STA_WORDS*WORD_W-1:0] station_addr,
    output logic                        ee_cs,
    output logic                        ee_sk,
    output logic                        ee_do,
    input  logic                        ee_di
);
    localparam int IDX_W = (STA_WORDS > 1) ? $clog2(STA_WORDS) : 1;

    init_state_e        ist;
    logic [IDX_W-1:0]   idx;
    logic               issued;
    logic               wide_q;
    logic [WORD_W-1:0]  sta_q [STA_WORDS];

    logic               eng_go;
    logic [ADDR_W-1:0]  eng_addr;
    logic               eng_wide;
    logic               eng_active;
    logic               eng_done;
    logic [WORD_W-1:0]  eng_word;

    uwire_read_engine #(
        .DIV_W(DIV_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W)
    ) eng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (clk_div),
        .go    (eng_go),
        .addr  (eng_addr),
        .wide  (eng_wide),
        .active(eng_active),
        .done  (eng_done),
        .word  (eng_word),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_do (ee_do),
        .ee_di (ee_di)
    );

    // Request mux: configuration sequencer first, host once ready.
    always_comb begin
        if (ist == I_READY) begin
            eng_go   = host_start;
            eng_addr = host_addr;
            eng_wide = host_wide;
        end else begin
            eng_go   = !issued && !eng_active;
            eng_addr = (ist == I_SIG) ? '0 : ADDR_W'(STA_BASE) + ADDR_W'(idx);
            eng_wide = (ist == I_SIG) ? 1'b1 : wide_q;
        end
    end

    // Configuration sequencer: signature read, then station address words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ist    <= I_SIG;
            idx    <= '0;
            issued <= 1'b0;
            wide_q <= 1'b0;
            for (int i = 0; i < STA_WORDS; i++) sta_q[i] <= '0;
        end else if (ist != I_READY) begin
            if (eng_go) issued <= 1'b1;
            if (eng_done) begin
                issued <= 1'b0;
                if (ist == I_SIG) begin
                    wide_q <= (eng_word == SIG_WORD);
                    idx    <= '0;
                    ist    <= I_STA;
                end else begin
                    sta_q[idx] <= eng_word;
                    if (idx == IDX_W'(STA_WORDS - 1)) ist <= I_READY;
                    else                              idx <= idx + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < STA_WORDS; g++) begin : g_sta
        assign station_addr[g*WORD_W +: WORD_W] = sta_q[g];
    end

    assign init_done = (ist == I_READY);
    assign busy      = (ist != I_READY) || eng_active;
    assign rd_done   = eng_done && (ist == I_READY);
    assign rd_word   = eng_word;
    assign wide_det  = wide_q;

    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !busy);

endmodule

// File: tb/uwire_eeprom_reader_tb_top.sv
`timescale 1ns/1ps
module uwire_eeprom_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd2;
    logic        host_start = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wide = 1'b1;
    logic [15:0] rd_word;
    logic        rd_done, busy, init_done, wide_det;
    logic [47:0] station_addr;
    logic        ee_cs, ee_sk, ee_do;
    logic        ee_di = 1'b0;

    always #5 clk = ~clk;

    uwire_eeprom_reader dut_i (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .host_start(host_start),
        .host_addr(host_addr), .host_wide(host_wide), .rd_word(rd_word),
        .rd_done(rd_done), .busy(busy), .init_done(init_done), .wide_det(wide_det),
        .station_addr(station_addr), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
        .ee_di(ee_di)
    );

    // Behavioural EEPROM with a selectable address width.
    logic [15:0] mem [256];
    int          mw = 8;
    int          bc;
    int          k;
    logic [7:0]  ad;

    always @(posedge ee_cs) begin
        bc = 0; ad = '0; k = 15; ee_di = 1'b0;
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            if (bc < 3 + mw) begin
                if (bc >= 3) ad = {ad[6:0], ee_do};
                bc++;
            end else begin
                ee_di = (k >= 0) ? mem[ad][k] : 1'b0;
                k--;
            end
        end
    end

    // Reference model: expected {cs, sk, do, busy, done} per cycle.
    logic [4:0]  q[$];
    logic [15:0] wq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit in_reset = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        logic [4:0] e;
        logic [4:0] a;
        @(posedge clk);
        #2;
        if (in_reset)          e = 5'b00010;
        else if (q.size() > 0) e = q.pop_front();
        else                   e = 5'b00000;
        a = {ee_cs, ee_sk, ee_do, busy, rd_done};
        chk(a === e, "R2/R3/R4/R6 per-cycle pins", 64'(a), 64'(e));
        if (e[0] && wq.size() > 0) begin
            logic [15:0] w;
            w = wq.pop_front();
            chk(rd_word === w, "R3 word value", 64'(rd_word), 64'(w));
        end
    endtask

    task automatic push_phase(input logic [2:0] pins, input int n, input logic b);
        for (int i = 0; i < n; i++) q.push_back({pins, b, 1'b0});
    endtask

    function automatic int eff_div();
        return (clk_div < 2) ? 2 : int'(clk_div);
    endfunction

    task automatic push_read(input int addr, input int w, input bit host);
        int L;
        int c;
        L = eff_div();
        c = (6 << w) | (addr & ((1 << w) - 1));
        push_phase(3'b000, L, 1'b1);
        push_phase(3'b100, L, 1'b1);
        for (int i = w + 2; i >= 0; i--) begin
            logic b;
            b = c[i];
            push_phase({1'b1, 1'b0, b}, L, 1'b1);
            push_phase({1'b1, 1'b1, b}, L, 1'b1);
        end
        push_phase(3'b100, L, 1'b1);
        for (int i = 0; i < 16; i++) begin
            push_phase(3'b110, L, 1'b1);
            push_phase(3'b100, L, 1'b1);
        end
        push_phase(3'b000, L, 1'b1);
        if (host) q.push_back(5'b00001);
    endtask

    task automatic drain();
        while (q.size() > 0) step();
    endtask

    // Configuration sequence as a series of device reads (R7, R8, R9).
    task automatic push_init(output int dw);
        logic [15:0] seen;
        seen = (mw == 8) ? mem[0] : 16'(mem[0] << 2);
        dw = (seen == 16'h8129) ? 8 : 6;
        push_read(0, 8, 1'b0);
        for (int j = 7; j <= 9; j++) begin
            push_phase(3'b000, 2, 1'b1);
            push_read(j, dw, 1'b0);
        end
        push_phase(3'b000, 1, 1'b1);
    endtask

    task automatic host_read(input int addr, input bit wide, input int poke_at);
        int w;
        w = wide ? 8 : 6;
        host_addr = 8'(addr);
        host_wide = wide;
        host_start = 1'b1;
        push_read(addr, w, 1'b1);
        wq.push_back(mem[addr & ((1 << w) - 1)]);
        step();
        host_start = 1'b0;
        if (poke_at > 0) begin
            for (int i = 0; i < poke_at; i++) step();
            host_addr = 8'h33;
            host_wide = ~wide;
            host_start = 1'b1;
            step();
            host_start = 1'b0;
        end
        drain();
    endtask

    task automatic do_reset(input int dev_w, input logic [15:0] w0, input logic [7:0] dv);
        in_reset = 1'b1;
        rst_n = 1'b0;
        q.delete();
        wq.delete();
        mw = dev_w;
        mem[0] = w0;
        clk_div = dv;
        for (int i = 0; i < 3; i++) step();
        chk(init_done === 1'b0, "R1 init_done low in reset", 64'(init_done), 64'd0);
        chk(rd_done === 1'b0, "R1 rd_done low in reset", 64'(rd_done), 64'd0);
    endtask

    initial begin
        int dw;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0107) ^ 16'h5A3C;

        // Scenario 1: 8-bit part carrying the signature.
        do_reset(8, 16'h8129, 8'd2);
        rst_n = 1'b1;
        in_reset = 1'b0;
        push_init(dw);
        drain();
        step();
        chk(init_done === 1'b1, "R8 init_done after configuration", 64'(init_done), 64'd1);
        chk(wide_det === 1'b1, "R7 wide part detected", 64'(wide_det), 64'd1);
        chk(station_addr === {mem[9], mem[8], mem[7]}, "R8 station address",
            station_addr, {mem[9], mem[8], mem[7]});

        // Host reads at the widest address and a mid value, slower phases.
        clk_div = 8'd3;
        host_read(8'hFF, 1'b1, 0);
        host_read(8'h5A, 1'b1, 0);
        // Start while busy is ignored (R6).
        host_read(8'h21, 1'b1, 15);
        // Divider below the minimum clamps to 2 (R4).
        clk_div = 8'd0;
        host_read(8'h10, 1'b1, 0);
        clk_div = 8'd1;
        host_read(8'h81, 1'b1, 0);

        // Scenario 2: 6-bit part, no signature; starts fired during configuration.
        do_reset(6, 16'h1234, 8'd4);
        rst_n = 1'b1;
        in_reset = 1'b0;
        push_init(dw);
        for (int i = 0; i < 30; i++) step();
        host_addr = 8'h04;
        host_start = 1'b1;
        for (int i = 0; i < 3; i++) step();
        host_start = 1'b0;
        chk(init_done === 1'b0, "R8 still configuring", 64'(init_done), 64'd0);
        drain();
        step();
        chk(init_done === 1'b1, "R8 init_done on narrow part", 64'(init_done), 64'd1);
        chk(wide_det === 1'b0, "R7 narrow part detected", 64'(wide_det), 64'd0);
        chk(station_addr === {mem[9], mem[8], mem[7]}, "R8 station address narrow",
            station_addr, {mem[9], mem[8], mem[7]});

        // Narrow host reads: top address, and upper address bits ignored (R5).
        clk_div = 8'd2;
        host_read(8'h3F, 1'b0, 0);
        host_read(8'hC5, 1'b0, 0);
        host_read(8'h2A, 1'b0, 9);
        for (int i = 0; i < 4; i++) step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule